// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block is the translator stage of a stepper motor controller. It keeps a position within an eight-state stepping cycle and turns that position into four phase-drive levels for the power stage. The power stage may be two H-bridges for a two-phase bipolar motor, or four switch transistors for a four-phase unipolar motor. A pulse on the active-low step input moves the position by one state in half-step mode, or by two states in full-step mode. The direction input selects which way the cycle is walked.

Full-step drive has two kinds, two-phase-on (normal) and one-phase-on (wave). No input selects between them. The kind follows from the parity of the state the sequencer is on when full-step mode is taken: a two-state move never changes parity.

An active-low home request returns the position to the home state. An enable input gates the phase and inhibit outputs low without disturbing the position. A home indication is provided as an open-drain style pair of signals. All asynchronous control inputs are brought into the system clock domain before use. The position index and a one-phase-on flag are exported for the current-reference selection logic elsewhere.

Top module: `stepSequencer`

## Requirements
- R1: After rstN is low, and on the third rising clk edge after homeReqN is seen low, stateIdx is 0 and the pattern {pha,phb,phc,phd} is 0101.
- R2: phaseOut (bit 3 = pha, bit 0 = phd) follows stateIdx while enabled:
  - indices 0 to 3 give 0101, 0001, 1001, 1000;
  - indices 4 to 7 give 1010, 0010, 0110, 0100.
- R3: A step is taken only on a low-to-high transition of stepN. stateIdx takes its new value on the third rising clk edge after that transition and is stable on the two edges before it.
- R4: With dirFwd = 1 a step raises stateIdx. With dirFwd = 0 it lowers it. Both wrap modulo 8.
- R5: The step size is set by halfMode. With halfMode = 1 each step moves stateIdx by one; with halfMode = 0 it moves it by two, so the parity of stateIdx is kept.
- R6: onePhaseOn is 1 exactly at odd stateIdx, where one phase is on. Full-step mode taken at an odd index gives wave drive (one phase on at every position), and taken at an even index gives normal drive (two phases on at every position).
- R7: Whenever enable is 0, phaseOut is 0000 and inhibitOut is 00. Whenever enable is 1, inhibitOut is 11. Steps taken while enable is 0 still move stateIdx.
- R8: When stateIdx is 0, homeOe is 1 and homeFlagN is 0. At every other index, homeOe is 0 and homeFlagN is 1.
- R9: A home request has priority over a step. Steps given while homeReqN is held low leave stateIdx at 0. Stepping resumes from 0 once the request is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| stepN | input | 1 | Active-low step pulse, asynchronous; the step is taken on its rising edge |
| dirFwd | input | 1 | Direction: 1 forward, 0 reverse |
| halfMode | input | 1 | Step size: 1 half-step, 0 full-step |
| homeReqN | input | 1 | Active-low request to return to home, asynchronous |
| enable | input | 1 | Output gate; 0 forces phase and inhibit outputs low |
| phaseOut | output | 4 | Phase drives {pha,phb,phc,phd} |
| inhibitOut | output | 2 | Active-low inhibit controls for the two driver stages |
| homeFlagN | output | 1 | Home flag, low at home |
| homeOe | output | 1 | Output enable of the open-drain home pin, driven at home |
| stateIdx | output | 3 | Current position index 0..7 |
| onePhaseOn | output | 1 | High when the current position has one phase on |

## Verification
The bench walks the sequence across both wrap points in both directions and switches between half and full step at odd and even indices. A wrong modulo would lose the wrap, and a full-step move that broke parity would mix wave and normal drive. It measures the step latency edge by edge, since a detector on the falling edge or a missing synchroniser stage would move the position a cycle early or late. Steps are given while the home request is held, and a design that let a step win over the request would leave home. Steps are also given while the outputs are disabled, to show that the gate masks the outputs but does not freeze the position.

// File: rtl/stepSeqPkg.sv
package stepSeqPkg;

  localparam int unsigned IDX_W      = 3;
  localparam int unsigned NUM_STATES = 1 << IDX_W;
  localparam int unsigned PHASE_W    = 4;
  localparam logic [IDX_W-1:0] HOME_IDX = '0;

  // Strobes from control to datapath
  typedef struct packed {
    logic goHome;  // hold position at home
    logic stepEn;  // take one step this cycle
    logic fwd;     // direction of the step
    logic dbl;     // move two states instead of one
  } seqStrobe_t;

  // Phase pattern {pha,phb,phc,phd} for each position
  function automatic logic [PHASE_W-1:0] phasePattern(input logic [IDX_W-1:0] idx);
    logic [PHASE_W-1:0] pat;
    case (idx)
      3'd0: pat = 4'b0101;
      3'd1: pat = 4'b0001;
      3'd2: pat = 4'b1001;
      3'd3: pat = 4'b1000;
      3'd4: pat = 4'b1010;
      3'd5: pat = 4'b0010;
      3'd6: pat = 4'b0110;
      default: pat = 4'b0100;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/syncChain.sv
module syncChain #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= RESET_VAL;
          else       stageQ[s] <= dIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= RESET_VAL;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign dOut = stageQ[STAGES-1];

endmodule

// File: rtl/stepCtrl.sv
module stepCtrl
  import stepSeqPkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepN,
  input  logic       dirFwd,
  input  logic       halfMode,
  input  logic       homeReqN,
  output seqStrobe_t strb
);

  localparam int unsigned NUM_IN = 4;
  // bit order: {homeReqN, stepN, dirFwd, halfMode}
  localparam logic [NUM_IN-1:0] SYNC_RST = 4'b1101;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncIn;
  logic homeS, stepS, dirS, halfS;
  logic stepPrev;

  assign rawIn = {homeReqN, stepN, dirFwd, halfMode};

  syncChain #(
    .WIDTH    (NUM_IN),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(SYNC_RST)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .dIn (rawIn),
    .dOut(syncIn)
  );

  assign {homeS, stepS, dirS, halfS} = syncIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepPrev <= 1'b1;
    else       stepPrev <= stepS;
  end

  always_comb begin
    strb.goHome = ~homeS;
    strb.stepEn = stepS & ~stepPrev & homeS;
    strb.fwd    = dirS;
    strb.dbl    = ~halfS;
  end

endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import stepSeqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strb,
  input  logic               enable,
  output logic [PHASE_W-1:0] phaseOut,
  output logic [1:0]         inhibitOut,
  output logic               homeFlagN,
  output logic               homeOe,
  output logic [IDX_W-1:0]   stateIdx,
  output logic               onePhaseOn
);

  logic [IDX_W-1:0] posQ;
  logic [IDX_W-1:0] posNext;
  logic [IDX_W-1:0] moveBy;
  logic             atHome;

  always_comb begin
    moveBy  = strb.dbl ? IDX_W'(2) : IDX_W'(1);
    posNext = strb.fwd ? posQ + moveBy : posQ - moveBy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            posQ <= HOME_IDX;
    else if (strb.goHome) posQ <= HOME_IDX;
    else if (strb.stepEn) posQ <= posNext;
  end

  assign atHome     = (posQ == HOME_IDX);
  assign stateIdx   = posQ;
  assign onePhaseOn = posQ[0];
  assign phaseOut   = enable ? phasePattern(posQ) : '0;
  assign inhibitOut = {2{enable}};
  assign homeOe     = atHome;
  assign homeFlagN  = ~atHome;

endmodule

// File: rtl/stepSequencer.sv
module stepSequencer
  import stepSeqPkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepN,
  input  logic       dirFwd,
  input  logic       halfMode,
  input  logic       homeReqN,
  input  logic       enable,
  output logic [3:0] phaseOut,
  output logic [1:0] inhibitOut,
  output logic       homeFlagN,
  output logic       homeOe,
  output logic [2:0] stateIdx,
  output logic       onePhaseOn
);

  seqStrobe_t strb;

  stepCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .stepN   (stepN),
    .dirFwd  (dirFwd),
    .halfMode(halfMode),
    .homeReqN(homeReqN),
    .strb    (strb)
  );

  seqDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .enable    (enable),
    .phaseOut  (phaseOut),
    .inhibitOut(inhibitOut),
    .homeFlagN (homeFlagN),
    .homeOe    (homeOe),
    .stateIdx  (stateIdx),
    .onePhaseOn(onePhaseOn)
  );

endmodule

// File: rtl/stepSequencerChk.sv
module stepSequencerChk (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic [3:0] phaseOut,
  input logic [1:0] inhibitOut,
  input logic       homeFlagN,
  input logic       homeOe,
  input logic [2:0] stateIdx,
  input logic       onePhaseOn
);

  // R7
  gate_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (phaseOut == 4'b0000 && inhibitOut == 2'b00));

  // R7
  gate_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> inhibitOut == 2'b11);

  // R6
  one_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> (onePhaseOn == ($countones(phaseOut) == 1)));

  // R8
  home_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateIdx == 3'd0) |-> (homeOe && !homeFlagN));

  // R8
  away_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateIdx != 3'd0) |-> (!homeOe && homeFlagN));

  // R5
  step_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stateIdx) |-> (stateIdx == 3'd0 ||
      3'(stateIdx - $past(stateIdx)) inside {3'd1, 3'd2, 3'd6, 3'd7}));

endmodule

bind stepSequencer stepSequencerChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .phaseOut  (phaseOut),
  .inhibitOut(inhibitOut),
  .homeFlagN (homeFlagN),
  .homeOe    (homeOe),
  .stateIdx  (stateIdx),
  .onePhaseOn(onePhaseOn)
);

// File: tb/stepSequencer_bench.sv
`timescale 1ns/1ps
module stepSequencer_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepN = 1'b1;
  logic dirFwd = 1'b1;
  logic halfMode = 1'b1;
  logic homeReqN = 1'b1;
  logic enable = 1'b1;
  logic [3:0] phaseOut;
  logic [1:0] inhibitOut;
  logic homeFlagN, homeOe, onePhaseOn;
  logic [2:0] stateIdx;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  stepSequencer u_stepSequencer (
    .clk(clk), .rstN(rstN), .stepN(stepN), .dirFwd(dirFwd),
    .halfMode(halfMode), .homeReqN(homeReqN), .enable(enable),
    .phaseOut(phaseOut), .inhibitOut(inhibitOut), .homeFlagN(homeFlagN),
    .homeOe(homeOe), .stateIdx(stateIdx), .onePhaseOn(onePhaseOn)
  );

  // {dirFwd, halfMode, expected index, expected pattern}
  localparam int NVEC = 17;
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 3'd1, 4'b0001},
    {1'b1, 1'b1, 3'd2, 4'b1001},
    {1'b1, 1'b0, 3'd4, 4'b1010},
    {1'b1, 1'b0, 3'd6, 4'b0110},
    {1'b1, 1'b0, 3'd0, 4'b0101},
    {1'b0, 1'b1, 3'd7, 4'b0100},
    {1'b0, 1'b0, 3'd5, 4'b0010},
    {1'b0, 1'b0, 3'd3, 4'b1000},
    {1'b1, 1'b0, 3'd5, 4'b0010},
    {1'b0, 1'b1, 3'd4, 4'b1010},
    {1'b0, 1'b1, 3'd3, 4'b1000},
    {1'b1, 1'b1, 3'd4, 4'b1010},
    {1'b1, 1'b1, 3'd5, 4'b0010},
    {1'b1, 1'b1, 3'd6, 4'b0110},
    {1'b1, 1'b1, 3'd7, 4'b0100},
    {1'b1, 1'b1, 3'd0, 4'b0101},
    {1'b0, 1'b0, 3'd6, 4'b0110}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doStep(input logic d, input logic h);
    @(negedge clk);
    dirFwd = d;
    halfMode = h;
    repeat (3) @(negedge clk);
    stepN = 1'b0;
    repeat (3) @(negedge clk);
    stepN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 and R8 reset state
    check("R1 reset idx", 32'(stateIdx), 32'd0);
    check("R1 reset pattern", 32'(phaseOut), 32'b0101);
    check("R8 reset homeOe", 32'(homeOe), 32'd1);
    check("R8 reset homeFlagN", 32'(homeFlagN), 32'd0);
    check("R7 inhibit enabled", 32'(inhibitOut), 32'b11);

    // R2 R4 R5 R6 vector walk
    for (int i = 0; i < NVEC; i++) begin
      doStep(VEC[i][8], VEC[i][7]);
      check($sformatf("R4/R5 vec %0d idx", i), 32'(stateIdx), 32'(VEC[i][6:4]));
      check($sformatf("R2 vec %0d pattern", i), 32'(phaseOut), 32'(VEC[i][3:0]));
      check($sformatf("R6 vec %0d onePhaseOn", i), 32'(onePhaseOn), 32'(VEC[i][4]));
      check($sformatf("R8 vec %0d homeOe", i), 32'(homeOe), 32'(VEC[i][6:4] == 3'd0));
    end

    // R3 latency: from index 6, forward half step to 7
    @(negedge clk);
    dirFwd = 1'b1;
    halfMode = 1'b1;
    repeat (3) @(negedge clk);
    stepN = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 no step on falling edge", 32'(stateIdx), 32'd6);
    stepN = 1'b1;
    @(negedge clk);
    check("R3 edge 1 stable", 32'(stateIdx), 32'd6);
    @(negedge clk);
    check("R3 edge 2 stable", 32'(stateIdx), 32'd6);
    @(negedge clk);
    check("R3 edge 3 moved", 32'(stateIdx), 32'd7);
    repeat (3) @(negedge clk);
    check("R3 single step only", 32'(stateIdx), 32'd7);

    // R7 enable gating, position keeps counting
    enable = 1'b0;
    @(negedge clk);
    check("R7 disabled phases", 32'(phaseOut), 32'd0);
    check("R7 disabled inhibit", 32'(inhibitOut), 32'd0);
    doStep(1'b1, 1'b1);
    check("R7 step while disabled idx", 32'(stateIdx), 32'd0);
    check("R7 still gated", 32'(phaseOut), 32'd0);
    enable = 1'b1;
    @(negedge clk);
    check("R7 re-enabled pattern", 32'(phaseOut), 32'b0101);
    check("R7 re-enabled inhibit", 32'(inhibitOut), 32'b11);

    // R1 R9 home request
    doStep(1'b1, 1'b1);
    doStep(1'b1, 1'b1);
    check("R9 setup idx", 32'(stateIdx), 32'd2);
    homeReqN = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 home request idx", 32'(stateIdx), 32'd0);
    check("R1 home request pattern", 32'(phaseOut), 32'b0101);
    doStep(1'b1, 1'b1);
    check("R9 step ignored during home request", 32'(stateIdx), 32'd0);
    check("R8 homeFlagN during request", 32'(homeFlagN), 32'd0);
    homeReqN = 1'b1;
    repeat (5) @(negedge clk);
    doStep(1'b1, 1'b1);
    check("R9 resume after release", 32'(stateIdx), 32'd1);
    check("R8 away homeOe", 32'(homeOe), 32'd0);

    finishRun();
  end

endmodule